// File: doc/BRIEF.md
# Stepper Stall Detection Monitor

This block watches the load on a stepper motor through a torque figure that upstream logic measures once per electrical half-cycle. Each new measurement arrives as a one-cycle strobe with a 12-bit value. The block keeps a sliding window of the latest four measurements and reports their mean as the torque count. When scaling is enabled and the mean is small, the count is multiplied by eight so that low readings from high-resistance coils still give useful resolution.

The reported count is compared with a 12-bit stall threshold. A count below the threshold means the motor is close to stalling, and the block then latches three sticky status flags. The active-low fault pin follows the stall flag only when stall reporting is enabled. Detection is only armed when the detector is enabled, the ripple-control decay mode is selected, no other fault is present and no threshold learning is in progress. A clear-faults command or a sleep-reset pulse drops every flag.

Software can write the threshold directly or let the block learn it. In learning, the motor is stalled on purpose. The block tracks the smallest valid count it sees, and on a stall-end strobe it loads that minimum plus one eighth of it as the new threshold, then raises a learn-OK flag.

Top module: `stall_monitor`

## Requirements
- R1: After reset the torque count is 0 and not valid, the threshold equals the parameter STALL_TH_RST (default 0), all flags and learn status are 0, and fault_n is 1.
- R2: On every meas_vld pulse the torque count becomes the mean (sum of the four newest samples shifted right by 2) of the latest four measurements, visible one clock after the strobe. torque_vld rises only on the fourth measurement since reset or since det_en was last 0, and no stall is flagged while it is 0.
- R3: Between measurement strobes the torque count holds its value.
- R4: When scale_en is 1 and the mean is below 500, the reported count is the mean times 8, saturated to 4095; otherwise the mean is reported unchanged.
- R5: When the valid count is strictly below the threshold and detection is armed, flag_stall, flag_stall_src and flag_fault are all set within two clocks of the count update, and they stay set until cleared. A count equal to the threshold does not flag.
- R6: Detection is armed only when det_en and ripple_mode are 1, other_fault is 0 and learning is idle.
- R7: fault_n is 0 exactly when flag_stall is 1 and report_en is 1.
- R8: A one-cycle pulse on clr_flt or sleep_pulse clears the three stall flags and learn_ok on the next clock, which releases fault_n.
- R9: A th_wr pulse loads th_wdata into the threshold on the next clock, unless learning is in progress, in which case the write is ignored.
- R10: learn_start, while idle, sets learn_busy. On stall_end, if at least one valid count was seen during learning, the threshold becomes min + (min >> 3) saturated at 4095. learn_ok is then set and learn_busy clears.
- R11: A stall_end while learning with no valid count seen ends learning with learn_ok 0 and the threshold unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| meas_vld | input | 1 | One-cycle strobe for a new half-cycle measurement |
| meas_cnt | input | 12 | Raw torque measurement |
| det_en | input | 1 | Stall detector enable |
| ripple_mode | input | 1 | Ripple-control decay mode selected |
| other_fault | input | 1 | Any other device fault active |
| scale_en | input | 1 | Enable ×8 scaling of low counts |
| report_en | input | 1 | Let a stall drive fault_n |
| clr_flt | input | 1 | Clear-faults command pulse |
| sleep_pulse | input | 1 | Sleep-reset pulse, clears faults |
| th_wr | input | 1 | Threshold write strobe |
| th_wdata | input | 12 | Threshold write value |
| learn_start | input | 1 | Start threshold learning |
| stall_end | input | 1 | End of the deliberate stall in learning |
| torque_cnt | output | 12 | Reported torque count |
| torque_vld | output | 1 | Torque count is based on four measurements |
| stall_th | output | 12 | Current stall threshold |
| flag_stall | output | 1 | Sticky stall flag |
| flag_stall_src | output | 1 | Sticky stall-type fault flag |
| flag_fault | output | 1 | Sticky general fault flag |
| learn_busy | output | 1 | Learning in progress |
| learn_ok | output | 1 | Last learning succeeded |
| fault_n | output | 1 | Active-low fault pin |

## Verification
The assertions assume that meas_vld, clr_flt, sleep_pulse, th_wr, learn_start and stall_end are single-cycle pulses driven in step with the clock, and that the mode inputs change only between strobes. The bench drives every input on the falling edge, and holds each strobe high for exactly one cycle. It moves det_en, ripple_mode, other_fault and report_en only while no measurement is in flight, so each output is sampled after the registers it passes through have settled.

// File: rtl/stall_pkg.sv
package stall_pkg;
    localparam int CNT_W   = 12;
    localparam int CNT_MAX = (1 << CNT_W) - 1;
    typedef logic [CNT_W-1:0] cnt_t;
endpackage

// File: rtl/torque_avg.sv
module torque_avg
    import stall_pkg::*;
#(
    parameter int DEPTH       = 4,
    parameter int SCALE_LIMIT = 500,
    parameter int SCALE_SHIFT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic meas_vld,
    input  cnt_t meas_cnt,
    input  logic scale_en,
    output cnt_t avg_cnt,
    output logic avg_vld,
    output logic avg_upd
);
    localparam int SHIFT = $clog2(DEPTH);
    localparam int SUM_W = CNT_W + SHIFT;
    localparam int NUM_W = $clog2(DEPTH + 1);
    localparam int WIDE_W = CNT_W + SCALE_SHIFT;

    typedef struct packed {
        logic [DEPTH-1:0][CNT_W-1:0] win;
        logic [NUM_W-1:0]            num;
        cnt_t                        cnt;
        logic                        vld;
        logic                        upd;
    } avg_st_t;

    avg_st_t st_d, st_q;
    logic [SUM_W-1:0]  sum_d;
    cnt_t              mean_d;
    logic [WIDE_W-1:0] wide_d;

    always_comb begin
        st_d     = st_q;
        st_d.upd = 1'b0;
        sum_d    = '0;
        mean_d   = '0;
        wide_d   = '0;
        if (meas_vld) begin
            st_d.win = {st_q.win[DEPTH-2:0], meas_cnt};
            for (int i = 0; i < DEPTH; i++) begin
                sum_d = sum_d + SUM_W'(st_d.win[i]);
            end
            mean_d = cnt_t'(sum_d >> SHIFT);
            wide_d = WIDE_W'(mean_d) << SCALE_SHIFT;
            if (scale_en && (int'(mean_d) < SCALE_LIMIT)) begin
                st_d.cnt = (wide_d > WIDE_W'(CNT_MAX)) ? cnt_t'(CNT_MAX) : cnt_t'(wide_d);
            end else begin
                st_d.cnt = mean_d;
            end
            st_d.upd = 1'b1;
            if (int'(st_q.num) < DEPTH) begin
                st_d.num = st_q.num + 1'b1;
            end
            st_d.vld = (int'(st_q.num) >= DEPTH - 1);
        end
        if (restart) begin
            st_d.num = '0;
            st_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign avg_cnt = st_q.cnt;
    assign avg_vld = st_q.vld;
    assign avg_upd = st_q.upd;

    a_r2_vld_on_update: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(avg_vld) |-> $past(meas_vld));
    a_r3_hold_count: assert property (@(posedge clk) disable iff (!rst_n)
        !meas_vld |=> $stable(avg_cnt));
endmodule

// File: rtl/stall_learn.sv
module stall_learn
    import stall_pkg::*;
#(
    parameter int MARGIN_SHIFT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic stall_end,
    input  logic cnt_upd,
    input  logic cnt_vld,
    input  cnt_t cnt,
    output logic busy,
    output logic done_ok,
    output cnt_t learned
);
    localparam int WIDE_W = CNT_W + 1;

    typedef struct packed {
        logic busy;
        logic have;
        cnt_t min;
    } lrn_st_t;

    lrn_st_t st_d, st_q;
    logic    take_d;
    cnt_t    min_eff;
    logic    have_eff;
    logic [WIDE_W-1:0] sum_w;

    always_comb begin
        st_d     = st_q;
        take_d   = st_q.busy && cnt_upd && cnt_vld;
        min_eff  = (take_d && (!st_q.have || cnt < st_q.min)) ? cnt : st_q.min;
        have_eff = st_q.have || take_d;
        sum_w    = WIDE_W'(min_eff) + WIDE_W'(min_eff >> MARGIN_SHIFT);
        learned  = (sum_w > WIDE_W'(CNT_MAX)) ? cnt_t'(CNT_MAX) : cnt_t'(sum_w);
        done_ok  = st_q.busy && stall_end && have_eff;
        if (st_q.busy) begin
            st_d.min  = min_eff;
            st_d.have = have_eff;
            if (stall_end) st_d.busy = 1'b0;
        end else if (start) begin
            st_d.busy = 1'b1;
            st_d.have = 1'b0;
            st_d.min  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.busy;

    a_r10_end_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && stall_end) |=> !busy);
    a_r10_min_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && $past(st_q.have)) |-> (st_q.min <= $past(st_q.min)));
endmodule

// File: rtl/stall_monitor.sv
module stall_monitor
    import stall_pkg::*;
#(
    parameter int   DEPTH        = 4,
    parameter int   SCALE_LIMIT  = 500,
    parameter int   SCALE_SHIFT  = 3,
    parameter int   MARGIN_SHIFT = 3,
    parameter logic [CNT_W-1:0] STALL_TH_RST = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             meas_vld,
    input  logic [CNT_W-1:0] meas_cnt,
    input  logic             det_en,
    input  logic             ripple_mode,
    input  logic             other_fault,
    input  logic             scale_en,
    input  logic             report_en,
    input  logic             clr_flt,
    input  logic             sleep_pulse,
    input  logic             th_wr,
    input  logic [CNT_W-1:0] th_wdata,
    input  logic             learn_start,
    input  logic             stall_end,
    output logic [CNT_W-1:0] torque_cnt,
    output logic             torque_vld,
    output logic [CNT_W-1:0] stall_th,
    output logic             flag_stall,
    output logic             flag_stall_src,
    output logic             flag_fault,
    output logic             learn_busy,
    output logic             learn_ok,
    output logic             fault_n
);
    typedef struct packed {
        cnt_t th;
        logic stall;
        logic src;
        logic flt;
        logic ok;
    } top_st_t;

    top_st_t st_d, st_q;
    cnt_t avg_cnt, learned;
    logic avg_vld, avg_upd, busy, done_ok;
    logic armed, hit, clear;

    torque_avg #(
        .DEPTH(DEPTH), .SCALE_LIMIT(SCALE_LIMIT), .SCALE_SHIFT(SCALE_SHIFT)
    ) u_avg (
        .clk(clk), .rst_n(rst_n), .restart(!det_en),
        .meas_vld(meas_vld), .meas_cnt(meas_cnt), .scale_en(scale_en),
        .avg_cnt(avg_cnt), .avg_vld(avg_vld), .avg_upd(avg_upd)
    );

    stall_learn #(.MARGIN_SHIFT(MARGIN_SHIFT)) u_learn (
        .clk(clk), .rst_n(rst_n), .start(learn_start), .stall_end(stall_end),
        .cnt_upd(avg_upd), .cnt_vld(avg_vld), .cnt(avg_cnt),
        .busy(busy), .done_ok(done_ok), .learned(learned)
    );

    always_comb begin
        st_d  = st_q;
        armed = det_en && ripple_mode && !other_fault && !busy;
        hit   = armed && avg_vld && (avg_cnt < st_q.th);
        clear = clr_flt || sleep_pulse;
        if (done_ok) begin
            st_d.th = learned;
            st_d.ok = 1'b1;
        end else if (th_wr && !busy) begin
            st_d.th = th_wdata;
        end
        if (hit) begin
            st_d.stall = 1'b1;
            st_d.src   = 1'b1;
            st_d.flt   = 1'b1;
        end
        if (clear) begin
            st_d.stall = 1'b0;
            st_d.src   = 1'b0;
            st_d.flt   = 1'b0;
            st_d.ok    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.th <= STALL_TH_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign torque_cnt     = avg_cnt;
    assign torque_vld     = avg_vld;
    assign stall_th       = st_q.th;
    assign flag_stall     = st_q.stall;
    assign flag_stall_src = st_q.src;
    assign flag_fault     = st_q.flt;
    assign learn_busy     = busy;
    assign learn_ok       = st_q.ok;
    assign fault_n        = !(st_q.stall && report_en);

    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_stall && !clr_flt && !sleep_pulse) |=> flag_stall);
    a_r6_quiet_when_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_stall && (!det_en || !ripple_mode || other_fault || learn_busy || !torque_vld))
        |=> !flag_stall);
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_flt || sleep_pulse) |=> (!flag_stall && !flag_fault && !learn_ok));
    a_r9_th_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (learn_busy && !stall_end) |=> $stable(stall_th));
    a_r7_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_n) |-> (flag_stall && report_en));
endmodule

// File: tb/stall_monitor_test.sv
module stall_monitor_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        meas_vld = 1'b0;
    logic [11:0] meas_cnt = '0;
    logic        det_en = 1'b1, ripple_mode = 1'b1, other_fault = 1'b0;
    logic        scale_en = 1'b0, report_en = 1'b0;
    logic        clr_flt = 1'b0, sleep_pulse = 1'b0;
    logic        th_wr = 1'b0;
    logic [11:0] th_wdata = '0;
    logic        learn_start = 1'b0, stall_end = 1'b0;
    logic [11:0] torque_cnt, stall_th;
    logic        torque_vld, flag_stall, flag_stall_src, flag_fault;
    logic        learn_busy, learn_ok, fault_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    stall_monitor uut (
        .clk(clk), .rst_n(rst_n), .meas_vld(meas_vld), .meas_cnt(meas_cnt),
        .det_en(det_en), .ripple_mode(ripple_mode), .other_fault(other_fault),
        .scale_en(scale_en), .report_en(report_en), .clr_flt(clr_flt),
        .sleep_pulse(sleep_pulse), .th_wr(th_wr), .th_wdata(th_wdata),
        .learn_start(learn_start), .stall_end(stall_end),
        .torque_cnt(torque_cnt), .torque_vld(torque_vld), .stall_th(stall_th),
        .flag_stall(flag_stall), .flag_stall_src(flag_stall_src), .flag_fault(flag_fault),
        .learn_busy(learn_busy), .learn_ok(learn_ok), .fault_n(fault_n)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input int v);
        @(negedge clk);
        meas_vld = 1'b1;
        meas_cnt = 12'(v);
        @(negedge clk);
        meas_vld = 1'b0;
        idle(2);
    endtask

    task automatic pulse_clr();
        @(negedge clk); clr_flt = 1'b1;
        @(negedge clk); clr_flt = 1'b0;
    endtask

    task automatic write_th(input int v);
        @(negedge clk); th_wr = 1'b1; th_wdata = 12'(v);
        @(negedge clk); th_wr = 1'b0;
    endtask

    task automatic pulse_learn();
        @(negedge clk); learn_start = 1'b1;
        @(negedge clk); learn_start = 1'b0;
    endtask

    task automatic pulse_end();
        @(negedge clk); stall_end = 1'b1;
        @(negedge clk); stall_end = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 torque_cnt", torque_cnt, 0);
        check("R1 torque_vld", torque_vld, 0);
        check("R1 stall_th", stall_th, 0);
        check("R1 flags", {flag_stall, flag_stall_src, flag_fault, learn_busy, learn_ok}, 0);
        check("R1 fault_n", fault_n, 1);
    endtask

    task automatic t_average();
        push(100); push(200); push(300);
        check("R2 not valid before four", torque_vld, 0);
        push(400);
        check("R2 mean of four", torque_cnt, 250);
        check("R2 valid at fourth", torque_vld, 1);
        idle(6);
        check("R3 hold between strobes", torque_cnt, 250);
        push(800);
        check("R2 sliding window", torque_cnt, 425);
    endtask

    task automatic t_scale();
        scale_en = 1'b1;
        push(100);
        check("R4 scaled low mean", torque_cnt, 3200);
        push(600); push(600); push(600); push(600);
        check("R4 no scale at or above 500", torque_cnt, 600);
        scale_en = 1'b0;
    endtask

    task automatic t_threshold();
        write_th(600);
        check("R9 threshold write", stall_th, 600);
        idle(3);
        check("R5 equal does not flag", flag_stall, 0);
        write_th(601);
        idle(2);
        check("R5 stall flag", flag_stall, 1);
        check("R5 stall type flag", flag_stall_src, 1);
        check("R5 fault flag", flag_fault, 1);
        check("R7 pin quiet without report", fault_n, 1);
        report_en = 1'b1;
        idle(1);
        check("R7 pin low with report", fault_n, 0);
    endtask

    task automatic t_clear_gate();
        det_en = 1'b0;
        pulse_clr();
        check("R8 clr_flt clears flag", flag_stall, 0);
        check("R8 pin released", fault_n, 1);
        det_en = 1'b1;
        idle(3);
        check("R2 no stall while not valid", flag_stall, 0);
        push(600); push(600); push(600);
        check("R2 still no stall at three", flag_stall, 0);
        push(600);
        check("R5 stall after fourth", flag_stall, 1);
        other_fault = 1'b1;
        @(negedge clk); sleep_pulse = 1'b1;
        @(negedge clk); sleep_pulse = 1'b0;
        check("R8 sleep pulse clears", {flag_stall, flag_stall_src, flag_fault}, 0);
        idle(4);
        check("R6 other fault suppresses", flag_stall, 0);
        other_fault = 1'b0;
        idle(2);
        check("R6 detect after other fault", flag_stall, 1);
        ripple_mode = 1'b0;
        pulse_clr();
        idle(4);
        check("R6 decay mode gates", flag_stall, 0);
        ripple_mode = 1'b1;
        idle(2);
        check("R6 decay mode restored", flag_stall, 1);
        det_en = 1'b0;
        report_en = 1'b0;
        pulse_clr();
    endtask

    task automatic t_learn();
        pulse_learn();
        check("R10 busy after start", learn_busy, 1);
        write_th(50);
        check("R9 write ignored while learning", stall_th, 601);
        det_en = 1'b1;
        push(800); push(800); push(800); push(800);
        push(160); push(160); push(160); push(160);
        check("R6 no detect while learning", flag_stall, 0);
        pulse_end();
        check("R10 learned threshold", stall_th, 180);
        check("R10 learn ok", learn_ok, 1);
        check("R10 busy cleared", learn_busy, 0);
        idle(2);
        check("R5 detect with learned threshold", flag_stall, 1);
        det_en = 1'b0;
        pulse_clr();
        check("R8 clear drops learn ok", learn_ok, 0);
    endtask

    task automatic t_learn_sat();
        pulse_learn();
        det_en = 1'b1;
        push(4095); push(4095); push(4095); push(4095);
        pulse_end();
        check("R10 saturated threshold", stall_th, 4095);
        check("R10 ok on saturation", learn_ok, 1);
        idle(3);
        check("R5 equal count at 4095 no flag", flag_stall, 0);
        det_en = 1'b0;
        pulse_clr();
    endtask

    task automatic t_learn_fail();
        pulse_learn();
        pulse_end();
        check("R11 busy ends", learn_busy, 0);
        check("R11 no learn ok", learn_ok, 0);
        check("R11 threshold kept", stall_th, 4095);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_average();
        t_scale();
        t_threshold();
        t_clear_gate();
        t_learn();
        t_learn_sat();
        t_learn_fail();
        done = 1'b1;
        summary();
        $finish;
    end
endmodule